// File: doc/BRIEF.md
# Shadow Memory Region Controller

This block is the configuration side of a memory-routing unit for the top 256 KB of a one-megabyte address space. Software reaches it through two I/O ports: one port holds an 8-bit index, and the other reads or writes the byte of a 256-entry register file that the index selects. A few of those bytes decide, for every memory access in C0000h–FFFFFh, whether a read is served by on-board shadow RAM or by the external bus, and whether a write goes to shadow RAM, to the external bus, or is dropped.

The C0000h–EFFFFh window is cut into twelve 16 KB segments, and each segment has its own read-route bit and write-route bit. Each of the three 64 KB groups in that window also has a write-protect bit that overrides the write-route bits of its four segments. The F0000h–FFFFFh group has one read-route bit and one write-protect bit. The memory side asks about an address and gets three route flags back, decoded combinationally from the current register contents.

Top module: `shadow_map_ctrl`

## Requirements
- R1: An I/O write to port 0x22 loads the index. An I/O write to port 0x24 stores the byte into the entry selected by the index. The index never changes on data-port accesses, so repeated writes hit the same entry.
- R2: An I/O read of port 0x24 presents the selected entry on `io_rdata` in the clock cycle after the read strobe.
- R3: An I/O read of any port other than 0x24, including 0x22, presents 0xFF one cycle later.
- R4: After reset, entry 0x23 holds 0x40, and the index and every other entry hold 0x00.
- R5: In F0000h–FFFFFh, `rd_internal` is 1 when bit 6 of entry 0x23 is 0, and 0 when that bit is 1.
- R6: In F0000h–FFFFFh, `wr_disabled` equals bit 7 of entry 0x27 and `wr_internal` is its inverse.
- R7: Entries 0x26, 0x25 and 0x24 govern the C, D and E groups. For 16 KB segment n (0..3, counted upward from the group base, i.e. address bits 15:14), bit n+4 = 1 makes `rd_internal` 1.
- R8: In the same groups, bit n = 1 makes `wr_internal` 1, provided the group is not write-protected.
- R9: Bits 4, 5 and 6 of entry 0x27 write-protect the C, D and E groups. When the bit for a group is set, `wr_disabled` is 1 and `wr_internal` is 0 in all four of its segments, whatever their write bits hold.
- R10: For addresses below C0000h, all three route flags are 0.
- R11: `wr_internal` and `wr_disabled` are never 1 together.
- R12: A data-port write changes the route flags from the next clock cycle on. A write to the index port leaves the route flags unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| io_addr | input | 16 | I/O port address |
| io_wdata | input | 8 | I/O write data |
| io_wr | input | 1 | I/O write strobe, one cycle per access |
| io_rd | input | 1 | I/O read strobe, one cycle per access |
| io_rdata | output | 8 | Registered I/O read data |
| mem_addr | input | 20 | Memory access address to classify |
| rd_internal | output | 1 | Read served from shadow RAM (0: external bus) |
| wr_internal | output | 1 | Write goes to shadow RAM |
| wr_disabled | output | 1 | Write is dropped |

## Verification
The hardest behaviour to reach is a group write-protect bit overriding segment write bits that are themselves set. With the write bits at their reset value of zero, protection only turns `wr_internal` from 0 to 0 and so proves nothing. The stimulus therefore sets every segment write bit first, then toggles each protect bit on and off. After every single-bit toggle of a routing or protect bit, it probes the first and last byte of all sixteen 16 KB segments. This also catches a bit that drives the wrong segment or group, or a wrong segment boundary.

// File: rtl/smc_pkg.sv
package smc_pkg;

  // Routing answer for one memory access
  typedef struct packed {
    logic rd_int;   // read served from shadow RAM
    logic wr_int;   // write lands in shadow RAM
    logic wr_dis;   // write dropped
  } route_t;

  localparam int unsigned DATA_W = 8;

endpackage

// File: rtl/smc_io_port.sv
// Index/data port pair front end: index latch, strobe decode, read data register
module smc_io_port #(
  parameter int unsigned           IO_AW    = 16,
  parameter int unsigned           DW       = 8,
  parameter logic [IO_AW-1:0]      IDX_PORT = 'h22,
  parameter logic [IO_AW-1:0]      DAT_PORT = 'h24,
  parameter logic [DW-1:0]         IDLE_VAL = '1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [IO_AW-1:0] io_addr,
  input  logic [DW-1:0]    io_wdata,
  input  logic             io_wr,
  input  logic             io_rd,
  input  logic [DW-1:0]    cur_byte,
  output logic [DW-1:0]    index,
  output logic             dat_we,
  output logic [DW-1:0]    io_rdata
);

  logic hit_idx, hit_dat;

  always_comb begin
    hit_idx = (io_addr == IDX_PORT);
    hit_dat = (io_addr == DAT_PORT);
    dat_we  = io_wr && hit_dat;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      index <= '0;
    end else if (io_wr && hit_idx) begin
      index <= io_wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      io_rdata <= IDLE_VAL;
    end else if (io_rd) begin
      io_rdata <= hit_dat ? cur_byte : IDLE_VAL;
    end
  end

endmodule

// File: rtl/smc_regfile.sv
// Indexed configuration byte array with per-entry reset values and taps
module smc_regfile #(
  parameter int unsigned   DW        = 8,
  parameter int unsigned   NREG      = 256,
  parameter int unsigned   NGRP      = 3,
  parameter int unsigned   REG_BIOS  = 'h23,
  parameter int unsigned   REG_GRP_HI= 'h24,
  parameter int unsigned   REG_WP    = 'h27,
  parameter logic [DW-1:0] BIOS_RST  = 'h40,
  localparam int unsigned  IW        = $clog2(NREG)
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [IW-1:0]            index,
  input  logic                     we,
  input  logic [DW-1:0]            wdata,
  output logic [DW-1:0]            cur_byte,
  output logic [DW-1:0]            bios_cfg,
  output logic [DW-1:0]            wp_cfg,
  output logic [NGRP-1:0][DW-1:0]  grp_cfg
);

  logic [DW-1:0] regs [NREG];

  function automatic logic [DW-1:0] rst_val(int unsigned k);
    return (k == REG_BIOS) ? BIOS_RST : '0;
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int unsigned k = 0; k < NREG; k++) begin
        regs[k] <= rst_val(k);
      end
    end else if (we) begin
      regs[index] <= wdata;
    end
  end

  always_comb begin
    cur_byte = regs[index];
    bios_cfg = regs[REG_BIOS];
    wp_cfg   = regs[REG_WP];
  end

  // Group 0 is the lowest 64 KB group; its control byte is the highest index
  for (genvar g = 0; g < NGRP; g++) begin : g_tap
    assign grp_cfg[g] = regs[REG_GRP_HI + NGRP - 1 - g];
  end

endmodule

// File: rtl/smc_decode.sv
// Combinational address-to-route decode for the upper groups of the map
module smc_decode
  import smc_pkg::*;
#(
  parameter int unsigned DW         = 8,
  parameter int unsigned AW         = 20,
  parameter int unsigned GRP_W      = 16,
  parameter int unsigned SEG_W      = 14,
  parameter int unsigned NGRP       = 3,
  parameter int unsigned WP_LSB     = 4,
  parameter int unsigned BIOS_RD_BIT= 6,
  localparam int unsigned TAG_W     = AW - GRP_W,
  localparam int unsigned SI_W      = GRP_W - SEG_W,
  localparam int unsigned NSEG      = 1 << SI_W,
  localparam int unsigned TOP_GRP   = (1 << TAG_W) - 1,
  localparam int unsigned FIRST_GRP = TOP_GRP - NGRP
) (
  input  logic [AW-1:0]           mem_addr,
  input  logic [DW-1:0]           bios_cfg,
  input  logic [DW-1:0]           wp_cfg,
  input  logic [NGRP-1:0][DW-1:0] grp_cfg,
  output route_t                  route
);

  logic [TAG_W-1:0] tag;
  logic [SI_W-1:0]  seg;
  logic [NGRP-1:0]  hit;
  route_t           grp_route [NGRP];
  route_t           top_route;

  assign tag = mem_addr[AW-1:GRP_W];
  assign seg = mem_addr[GRP_W-1:SEG_W];

  for (genvar g = 0; g < NGRP; g++) begin : g_grp
    logic prot;
    assign hit[g] = (tag == TAG_W'(FIRST_GRP + g));
    assign prot   = wp_cfg[WP_LSB + g];
    always_comb begin
      grp_route[g].rd_int = grp_cfg[g][NSEG + 32'(seg)];
      grp_route[g].wr_dis = prot;
      grp_route[g].wr_int = !prot && grp_cfg[g][seg];
    end
  end

  always_comb begin
    top_route.rd_int = !bios_cfg[BIOS_RD_BIT];
    top_route.wr_dis = wp_cfg[WP_LSB + NGRP];
    top_route.wr_int = !wp_cfg[WP_LSB + NGRP];
  end

  always_comb begin
    route = '0;
    if (tag == TAG_W'(TOP_GRP)) begin
      route = top_route;
    end
    for (int g = 0; g < NGRP; g++) begin
      if (hit[g]) route = grp_route[g];
    end
  end

endmodule

// File: rtl/shadow_map_ctrl.sv
// Shadow memory region controller top
module shadow_map_ctrl
  import smc_pkg::*;
#(
  parameter int unsigned IO_AW      = 16,
  parameter int unsigned AW         = 20,
  parameter int unsigned NREG       = 256,
  parameter int unsigned NGRP       = 3,
  parameter int unsigned IDX_PORT   = 'h22,
  parameter int unsigned DAT_PORT   = 'h24,
  parameter int unsigned REG_BIOS   = 'h23,
  parameter int unsigned REG_GRP_HI = 'h24,
  parameter int unsigned REG_WP     = 'h27,
  localparam int unsigned DW        = DATA_W,
  localparam int unsigned IW        = $clog2(NREG)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [IO_AW-1:0] io_addr,
  input  logic [DW-1:0]    io_wdata,
  input  logic             io_wr,
  input  logic             io_rd,
  output logic [DW-1:0]    io_rdata,
  input  logic [AW-1:0]    mem_addr,
  output logic             rd_internal,
  output logic             wr_internal,
  output logic             wr_disabled
);

  logic [DW-1:0]           index;
  logic                    dat_we;
  logic [DW-1:0]           cur_byte;
  logic [DW-1:0]           bios_cfg;
  logic [DW-1:0]           wp_cfg;
  logic [NGRP-1:0][DW-1:0] grp_cfg;
  route_t                  route;

  smc_io_port #(
    .IO_AW   (IO_AW),
    .DW      (DW),
    .IDX_PORT(IO_AW'(IDX_PORT)),
    .DAT_PORT(IO_AW'(DAT_PORT)),
    .IDLE_VAL('1)
  ) u_io (
    .clk     (clk),
    .rst     (rst),
    .io_addr (io_addr),
    .io_wdata(io_wdata),
    .io_wr   (io_wr),
    .io_rd   (io_rd),
    .cur_byte(cur_byte),
    .index   (index),
    .dat_we  (dat_we),
    .io_rdata(io_rdata)
  );

  smc_regfile #(
    .DW        (DW),
    .NREG      (NREG),
    .NGRP      (NGRP),
    .REG_BIOS  (REG_BIOS),
    .REG_GRP_HI(REG_GRP_HI),
    .REG_WP    (REG_WP),
    .BIOS_RST  ('h40)
  ) u_rf (
    .clk     (clk),
    .rst     (rst),
    .index   (index[IW-1:0]),
    .we      (dat_we),
    .wdata   (io_wdata),
    .cur_byte(cur_byte),
    .bios_cfg(bios_cfg),
    .wp_cfg  (wp_cfg),
    .grp_cfg (grp_cfg)
  );

  smc_decode #(
    .DW  (DW),
    .AW  (AW),
    .NGRP(NGRP)
  ) u_dec (
    .mem_addr(mem_addr),
    .bios_cfg(bios_cfg),
    .wp_cfg  (wp_cfg),
    .grp_cfg (grp_cfg),
    .route   (route)
  );

  assign rd_internal = route.rd_int;
  assign wr_internal = route.wr_int;
  assign wr_disabled = route.wr_dis;

endmodule

// File: rtl/smc_chk.sv
// Property checker attached to the controller top
module smc_chk #(
  parameter int unsigned IO_AW    = 16,
  parameter int unsigned AW       = 20,
  parameter int unsigned IDX_PORT = 'h22,
  parameter int unsigned DAT_PORT = 'h24
) (
  input logic             clk,
  input logic             rst,
  input logic [IO_AW-1:0] io_addr,
  input logic             io_wr,
  input logic             io_rd,
  input logic [7:0]       io_rdata,
  input logic [AW-1:0]    mem_addr,
  input logic             rd_internal,
  input logic             wr_internal,
  input logic             wr_disabled
);

  localparam logic [AW-1:0] LOW_END = AW'('hC0000);

  // R11: never route a write both to shadow RAM and nowhere
  p_excl_wr_r11: assert property (@(posedge clk) disable iff (rst)
    !(wr_internal && wr_disabled));

  // R10: low memory always goes to the external bus
  p_low_ext_r10: assert property (@(posedge clk) disable iff (rst)
    (mem_addr < LOW_END) |-> (!rd_internal && !wr_internal && !wr_disabled));

  // R3: reads of a non-data port return all ones
  p_idle_read_r3: assert property (@(posedge clk) disable iff (rst)
    ($past(!rst) && $past(io_rd) && $past(io_addr) != IO_AW'(DAT_PORT))
      |-> (io_rdata == 8'hFF));

  // R12: without a preceding data-port write, a steady address gives steady flags
  p_hold_r12: assert property (@(posedge clk) disable iff (rst)
    ($past(!rst) && $stable(mem_addr) &&
     !($past(io_wr) && $past(io_addr) == IO_AW'(DAT_PORT)))
      |-> $stable({rd_internal, wr_internal, wr_disabled}));

  // R2: read data only moves after a read strobe
  p_rdata_hold_r2: assert property (@(posedge clk) disable iff (rst)
    ($past(!rst) && !$past(io_rd)) |-> $stable(io_rdata));

endmodule

bind shadow_map_ctrl smc_chk #(
  .IO_AW   (IO_AW),
  .AW      (AW),
  .IDX_PORT(IDX_PORT),
  .DAT_PORT(DAT_PORT)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .io_addr    (io_addr),
  .io_wr      (io_wr),
  .io_rd      (io_rd),
  .io_rdata   (io_rdata),
  .mem_addr   (mem_addr),
  .rd_internal(rd_internal),
  .wr_internal(wr_internal),
  .wr_disabled(wr_disabled)
);

// File: tb/shadow_map_ctrl_tb.sv
module shadow_map_ctrl_tb;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] io_addr = '0;
  logic [7:0]  io_wdata = '0;
  logic        io_wr = 1'b0;
  logic        io_rd = 1'b0;
  logic [7:0]  io_rdata;
  logic [19:0] mem_addr = '0;
  logic        rd_internal, wr_internal, wr_disabled;

  always #5 clk = ~clk;

  shadow_map_ctrl u_dut (
    .clk(clk), .rst(rst), .io_addr(io_addr), .io_wdata(io_wdata),
    .io_wr(io_wr), .io_rd(io_rd), .io_rdata(io_rdata), .mem_addr(mem_addr),
    .rd_internal(rd_internal), .wr_internal(wr_internal), .wr_disabled(wr_disabled)
  );

  typedef struct {
    bit       is_rd;
    bit [7:0] exp;
    string    tag;
  } item_t;

  item_t    q[$];
  int       n_chk = 0;
  int       n_bad = 0;
  bit       done  = 0;
  bit [7:0] mdl [256];
  bit [7:0] midx;

  // Expected route {rd_int, wr_int, wr_dis} from the requirements
  function automatic bit [7:0] exp_route(bit [19:0] a);
    bit [3:0] g = a[19:16];
    int       s = int'(a[15:14]);
    bit [7:0] r;
    bit       rd, wi, wd;
    rd = 0; wi = 0; wd = 0;
    if (g == 4'hF) begin                   // R5, R6
      rd = !mdl[8'h23][6];
      wd = mdl[8'h27][7];
      wi = !wd;
    end else if (g >= 4'hC) begin          // R7, R8, R9
      r  = (g == 4'hE) ? mdl[8'h24] : (g == 4'hD) ? mdl[8'h25] : mdl[8'h26];
      rd = r[s + 4];
      wd = mdl[8'h27][int'(g) - 12 + 4];
      wi = !wd && r[s];
    end
    return {5'b0, rd, wi, wd};
  endfunction

  task automatic io_write(bit [15:0] a, bit [7:0] d);
    io_addr = a; io_wdata = d; io_wr = 1'b1;
    @(negedge clk);
    io_wr = 1'b0;
    if (a == 16'h22) midx = d;
    else if (a == 16'h24) mdl[midx] = d;
  endtask

  task automatic io_read(bit [15:0] a, string tag);
    item_t it;
    io_addr = a; io_rd = 1'b1;
    it.is_rd = 1; it.exp = (a == 16'h24) ? mdl[midx] : 8'hFF; it.tag = tag;
    q.push_back(it);
    @(negedge clk);
    io_rd = 1'b0;
  endtask

  task automatic probe(bit [19:0] a, string tag);
    item_t it;
    mem_addr = a;
    it.is_rd = 0; it.exp = exp_route(a); it.tag = tag;
    q.push_back(it);
    @(negedge clk);
  endtask

  task automatic set_reg(bit [7:0] r, bit [7:0] v);
    io_write(16'h22, r);
    io_write(16'h24, v);
  endtask

  // First and last byte of every 16 KB segment from C0000h up, plus low memory
  task automatic sweep(string tag);
    probe(20'h00000, "R10");
    probe(20'hBFFFF, "R10");
    for (int g = 12; g < 16; g++) begin
      for (int s = 0; s < 4; s++) begin
        probe({g[3:0], s[1:0], 14'h0000}, tag);
        probe({g[3:0], s[1:0], 14'h3FFF}, tag);
      end
    end
  endtask

  // Monitor: one scoreboard item per cycle, sampled after the edge
  initial begin
    item_t    it;
    bit [7:0] act;
    forever begin
      @(posedge clk);
      #2;
      if (q.size() > 0) begin
        it  = q.pop_front();
        act = it.is_rd ? io_rdata : {5'b0, rd_internal, wr_internal, wr_disabled};
        n_chk++;
        if (act !== it.exp) begin
          n_bad++;
          $display("FAIL %s: actual=%02h expected=%02h", it.tag, act, it.exp);
        end
      end
    end
  end

  initial begin
    #2000000;
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    for (int k = 0; k < 256; k++) mdl[k] = 8'h00;
    mdl[8'h23] = 8'h40;
    midx = 8'h00;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R4: reset contents, index starts at 0
    io_read(16'h24, "R4");
    probe(20'hF0000, "R4");
    probe(20'hC0000, "R4");
    io_write(16'h22, 8'h23);
    io_read(16'h24, "R4");
    io_write(16'h22, 8'h27);
    io_read(16'h24, "R4");

    // R3: non-data ports read as all ones
    io_read(16'h22, "R3");
    io_read(16'h23, "R3");
    io_read(16'h0024 | 16'h0100, "R3");

    // R1 / R2: store and read back, index does not advance
    io_write(16'h22, 8'h40);
    io_write(16'h24, 8'h11);
    io_write(16'h24, 8'h5A);
    io_read(16'h24, "R1");
    io_read(16'h24, "R2");
    io_write(16'h22, 8'h41);
    io_read(16'h24, "R1");
    io_write(16'h22, 8'h40);
    io_read(16'h24, "R2");

    sweep("R10");

    // R7 / R8: toggle every routing bit of the three group bytes
    for (int r = 8'h24; r <= 8'h26; r++) begin
      for (int b = 0; b < 8; b++) begin
        set_reg(r[7:0], mdl[r] ^ (8'h01 << b));
        sweep(b >= 4 ? "R7" : "R8");
        set_reg(r[7:0], mdl[r] ^ (8'h01 << b));
        sweep(b >= 4 ? "R7" : "R8");
      end
    end

    // R9: protect bits override write bits that are set
    set_reg(8'h24, 8'h0F);
    set_reg(8'h25, 8'h0F);
    set_reg(8'h26, 8'h0F);
    for (int b = 4; b < 7; b++) begin
      set_reg(8'h27, mdl[8'h27] ^ (8'h01 << b));
      sweep("R9");
      set_reg(8'h27, mdl[8'h27] ^ (8'h01 << b));
      sweep("R9");
    end

    // R6: top group write protect
    set_reg(8'h27, 8'h80);
    sweep("R6");
    set_reg(8'h27, 8'h00);
    sweep("R6");

    // R5: top group read route
    set_reg(8'h23, 8'h00);
    sweep("R5");
    set_reg(8'h23, 8'h40);
    sweep("R5");

    // R12: effect on the cycle after the data write; index writes change nothing
    io_write(16'h22, 8'h25);
    mem_addr = 20'hDC000;
    io_write(16'h24, 8'h88);
    probe(20'hDC000, "R12");
    io_write(16'h22, 8'h00);
    probe(20'hDC000, "R12");
    io_write(16'h22, 8'h26);
    probe(20'hDC000, "R12");

    // Mixed pattern across all groups, R11 exclusivity covered by flag compare
    set_reg(8'h24, 8'hA5);
    set_reg(8'h25, 8'h3C);
    set_reg(8'h26, 8'h96);
    set_reg(8'h27, 8'h50);
    sweep("R11");

    repeat (3) @(negedge clk);
    done = 1;
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

endmodule